// File: doc/BRIEF.md
# Seeded Test Data Pattern Generator

This block maps a 32-bit integer seed to a deterministic data word for memory test traffic. The same seed always yields the same word, so a checker can rebuild the expected read data from nothing but the seed. The output is `DATA_W` bits wide, where `DATA_W` is a multiple of 32. The word is built from `LANES = DATA_W/32` lanes of 32 bits. Each lane works from its own derived seed, `seed * LANES + lane_index`, with all arithmetic taken modulo 2^32. In scrambled mode each lane applies an affine multiply-add, `derived * 0x31415979 + 1`. In raw mode each lane outputs its derived seed unchanged. Lane 0 sits in the most significant 32 bits, and higher lane indices follow toward bit 0. If `DATA_W` is not a multiple of 32, elaboration stops with an error.

Seeds enter on a valid/ready stream and words leave on another. With `REGISTERED = 1`, the default, one output register sits between the two streams. A seed is accepted on a clock edge where `in_valid` and `in_ready` are both high, and its word appears on the next cycle with `out_valid` high. While `out_valid` is high and `out_ready` is low, the output word is held and `in_ready` is low. With `REGISTERED = 0` the path is purely combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

Top module: `seed_pattern_gen`

## Requirements
- R1: In scrambled mode (`in_scramble` = 1) a lane word is `(d * 0x31415979 + 1) mod 2^32`, where `d` is the lane's derived seed. At `DATA_W` = 32, seed 0 gives 0x00000001 and seed 1 gives 0x3141597A.
- R2: In raw mode (`in_scramble` = 0) each lane word equals its derived seed. At `DATA_W` = 32 the output equals the input seed.
- R3: Lane i takes the derived seed `(seed * LANES + i) mod 2^32`. The multiply wraps, so at seed 0xFFFFFFFF with 4 lanes the raw lanes are 0xFFFFFFFC to 0xFFFFFFFF.
- R4: Lane 0 drives `out_data[DATA_W-1 -: 32]`, and lane i drives `out_data[DATA_W-1-32*i -: 32]`.
- R5: The mode select applies to all lanes of a word at once.
- R6: In the registered variant, `out_valid` is high in the cycle after an accepted seed and carries that seed's word. With `out_ready` high and no seed accepted, `out_valid` is low in the next cycle.
- R7: In the registered variant, while `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values and `in_ready` is low.
- R8: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A seed is offered |
| in_ready | output | 1 | The block can take a seed |
| in_seed | input | 32 | Seed value |
| in_scramble | input | 1 | 1 = scrambled pattern, 0 = raw derived seeds |
| out_valid | output | 1 | `out_data` holds a word |
| out_ready | input | 1 | The consumer takes the word |
| out_data | output | DATA_W | Generated word, lane 0 in the top bits |

## Verification
The assertions check on every cycle:
- the stream rules: a held word stays stable under back-pressure, `in_ready` drops while the word is held, and `out_valid` rises after an accepted seed and falls when nothing was accepted;
- a parity property of the scrambler: the multiplier is odd and the offset is one, so in scrambled mode a lane word's bit 0 is always the inverse of bit 0 of its derived seed.

Only the bench's scenarios can show the exact values:
- the full words over seeds 0 to 255 at widths 32, 64 and 128;
- the lane ordering;
- the wrap of the derived seed at the top of the seed range.

// File: rtl/spg_pkg.sv
package spg_pkg;
  localparam int unsigned LANE_W = 32;
  localparam logic [LANE_W-1:0] SCR_MULT = 32'h3141_5979;
  localparam logic [LANE_W-1:0] SCR_ADD  = 32'h0000_0001;

  // Derived seed for one lane; wraps modulo 2^32.
  function automatic logic [LANE_W-1:0] lane_seed(input logic [LANE_W-1:0] seed,
                                                  input int unsigned lanes,
                                                  input int unsigned idx);
    logic [LANE_W-1:0] prod;
    prod = seed * LANE_W'(lanes);
    return prod + LANE_W'(idx);
  endfunction

  // Affine multiply-add scrambler.
  function automatic logic [LANE_W-1:0] scramble(input logic [LANE_W-1:0] d);
    logic [LANE_W-1:0] prod;
    prod = d * SCR_MULT;
    return prod + SCR_ADD;
  endfunction
endpackage

// File: rtl/spg_lane.sv
module spg_lane
  import spg_pkg::*;
#(
  parameter int unsigned LANES    = 4,
  parameter int unsigned LANE_IDX = 0
) (
  input  logic [LANE_W-1:0] seed,
  input  logic              scramble_en,
  output logic [LANE_W-1:0] word
);
  logic [LANE_W-1:0] derived;
  logic [LANE_W-1:0] mixed;

  always_comb begin
    derived = lane_seed(seed, LANES, LANE_IDX);
    mixed   = scramble(derived);
    word    = scramble_en ? mixed : derived;
  end

  // The multiplier is odd and the offset is 1, so the scrambler inverts bit 0.
  always_comb begin
    if (scramble_en) begin
      AST_SCR_LSB_FLIP: assert (word[0] != derived[0]); // R1
    end
  end
endmodule

// File: rtl/spg_out_stage.sv
module spg_out_stage #(
  parameter int unsigned WIDTH      = 128,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  generate
    if (REGISTERED) begin : g_reg
      logic             vld_q;
      logic [WIDTH-1:0] dat_q;
      logic             take;

      assign in_ready  = !vld_q || out_ready;
      assign take      = in_valid && in_ready;
      assign out_valid = vld_q;
      assign out_data  = dat_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else begin
          if (in_ready) vld_q <= in_valid;
          if (take)     dat_q <= in_data;
        end
      end

      AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
      AST_STALL_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R7
      AST_VALID_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R6
      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && out_ready) |=> !out_valid); // R6
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/seed_pattern_gen.sv
module seed_pattern_gen
  import spg_pkg::*;
#(
  parameter int unsigned DATA_W     = 128,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_seed,
  input  logic              in_scramble,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int unsigned LANES = DATA_W / LANE_W;

  generate
    if ((DATA_W % LANE_W) != 0 || DATA_W == 0) begin : g_cfg_bad
      $error("seed_pattern_gen: DATA_W must be a nonzero multiple of 32");
    end
  endgenerate

  logic [DATA_W-1:0] word_comb;

  // Lane 0 at the top, ascending lane index toward bit 0.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] lw;
    spg_lane #(.LANES(LANES), .LANE_IDX(i)) u_lane (
      .seed        (in_seed),
      .scramble_en (in_scramble),
      .word        (lw)
    );
    assign word_comb[DATA_W-1-LANE_W*i -: LANE_W] = lw;
  end

  spg_out_stage #(.WIDTH(DATA_W), .REGISTERED(REGISTERED)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (word_comb),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: tb/seed_pattern_gen_tb.sv
module seed_pattern_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  in_seed = '0;
  logic         in_scramble = 1'b0;
  logic         out_ready = 1'b1;
  logic         rdy128, vld128;
  logic [127:0] d128;
  logic         rdy64, vld64, rdy32, vld32;
  logic [63:0]  d64;
  logic [31:0]  d32;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seed_pattern_gen #(.DATA_W(128), .REGISTERED(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy128),
    .in_seed(in_seed), .in_scramble(in_scramble), .out_valid(vld128),
    .out_ready(out_ready), .out_data(d128));
  seed_pattern_gen #(.DATA_W(64), .REGISTERED(1'b0)) u_w64 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy64),
    .in_seed(in_seed), .in_scramble(in_scramble), .out_valid(vld64),
    .out_ready(out_ready), .out_data(d64));
  seed_pattern_gen #(.DATA_W(32), .REGISTERED(1'b0)) u_w32 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy32),
    .in_seed(in_seed), .in_scramble(in_scramble), .out_valid(vld32),
    .out_ready(out_ready), .out_data(d32));

  function automatic logic [127:0] ref_word(input logic [31:0] seed, input bit scr, input int n);
    logic [127:0] acc = '0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] s;
      logic [31:0] w;
      s = seed * 32'(n) + 32'(i);
      w = scr ? (s * 32'h3141_5979 + 32'd1) : s;
      acc = (acc << 32) | {96'd0, w};
    end
    return acc;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one seed; check the combinational widths now, the registered one a cycle later.
  task automatic push_check(input logic [31:0] seed, input bit scr, input string req);
    in_seed = seed; in_scramble = scr; in_valid = 1'b1; out_ready = 1'b1;
    #1;
    check({req, " w32"}, {96'd0, d32}, {96'd0, ref_word(seed, scr, 1)[31:0]});
    check({req, " w64"}, {64'd0, d64}, {64'd0, ref_word(seed, scr, 2)[63:0]});
    @(negedge clk);
    check({req, " w128 valid"}, {127'd0, vld128}, 128'd1);
    check({req, " w128"}, d128, ref_word(seed, scr, 4));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 valid", {127'd0, vld128}, 128'd0);
    check("R8 ready", {127'd0, rdy128}, 128'd1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_known();
    push_check(32'd0, 1'b1, "R1 seed0");
    check("R1 seed0 value", {96'd0, d32}, 128'h1);
    push_check(32'd1, 1'b1, "R1 seed1");
    in_seed = 32'd1; #1;
    check("R1 seed1 value", {96'd0, d32}, 128'h3141_597A);
    in_valid = 1'b0;
  endtask

  task automatic t_sweep(input bit scr);
    for (int s = 0; s < 256; s++) push_check(32'(s), scr, scr ? "R1 R3 R4 R5 sweep" : "R2 R3 R4 R5 sweep");
    in_valid = 1'b0;
  endtask

  task automatic t_wrap();
    push_check(32'hFFFF_FFFF, 1'b0, "R3 wrap");
    check("R3 wrap lanes", d128, 128'hFFFFFFFC_FFFFFFFD_FFFFFFFE_FFFFFFFF);
    check("R4 lane0 top", {96'd0, d128[127:96]}, 128'hFFFF_FFFC);
    push_check(32'h8000_0001, 1'b1, "R3 R1 wrap scr");
    in_valid = 1'b0;
  endtask

  task automatic t_latency();
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check("R6 idle low", {127'd0, vld128}, 128'd0);
    in_seed = 32'd77; in_scramble = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 valid next", {127'd0, vld128}, 128'd1);
    check("R6 data", d128, ref_word(32'd77, 1'b1, 4));
    @(negedge clk);
    check("R6 drops", {127'd0, vld128}, 128'd0);
  endtask

  task automatic t_backpressure();
    out_ready = 1'b0; in_seed = 32'd10; in_scramble = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R7 first valid", {127'd0, vld128}, 128'd1);
    check("R7 stalled in_ready", {127'd0, rdy128}, 128'd0);
    in_seed = 32'd11; in_scramble = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 held data", d128, ref_word(32'd10, 1'b1, 4));
    check("R7 held valid", {127'd0, vld128}, 128'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 next word", d128, ref_word(32'd11, 1'b0, 4));
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_known();
    t_sweep(1'b1);
    t_sweep(1'b0);
    t_wrap();
    t_latency();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule